// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a 16-key switch matrix wired as four row lines and four column lines. It pulls one row low at a time, and the columns are held high by pull-ups. A column that reads low shows that the key where that column crosses the driven row is closed. If no column is low, the scanner moves on to the next row, wrapping from the last row back to the first, and repeats this without end.

When a closed key is found, the scanner stays on that row for a programmable debounce interval, nominally 10 ms expressed in clock cycles. It then reads the same column again. A key that is still closed is reported once: its hex code is placed on `key_code` and `key_valid` pulses for one cycle. The scanner then waits until every column reads high again before it resumes scanning, so holding a key down produces exactly one code. A key that has opened by the time of the recheck is discarded and scanning continues.

The column inputs are asynchronous to the clock and pass through a two-stage synchroniser. Each row is held for a settle window long enough for the synchronised columns to reflect that row.

Top module: `kps_scanner`

## Requirements
- R1: While `rst_n` is low, `row_drv_n` is 4'b1110 (row 0 driven), `key_valid` is 0 and `key_code` is 0.
- R2: Exactly one bit of `row_drv_n` is low at any time; bit r low selects row r.
- R3: With no key closed, the driven row advances every SETTLE_CYC cycles in the order 0,1,2,3,0. Each step moves the low bit up by one position (1110, 1101, 1011, 0111).
- R4: A column counts as closed when its line reads 0 through the two-stage synchroniser, at the end of the current row's settle window.
- R5: `key_valid` is high for exactly one cycle per accepted key.
- R6: The code of the key at row r, column c is r*4+c, shown as hex digits 0 to F. `key_code` changes only in a cycle where `key_valid` is high, and it holds its value between pulses.
- R7: After a detection, the same column is read again after DEBOUNCE_CYC cycles. A key that opens before that recheck produces no code, and bounce at press time produces at most one code.
- R8: After a code is reported, scanning stays on the same row until all columns read high, then resumes at the next row. One press gives one code however long it is held.
- R9: If several columns of the driven row are closed, the lowest column index is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_sense_n | input | 4 | Column lines, pulled high, low when a key in the driven row is closed |
| row_drv_n | output | 4 | Row drive, exactly one bit low |
| key_code | output | 4 | Code of the last accepted key |
| key_valid | output | 1 | One-cycle pulse when a new code is accepted |

## Verification
Four properties are checked on every cycle:
- exactly one row is driven;
- the driven row can only step to the next row in order;
- `key_valid` never lasts two cycles;
- `key_code` moves only alongside `key_valid`.

Whether a code is accepted at all depends on the whole press history: a glitch shorter than the debounce interval, bounce before a steady press, a press held long, or several keys in one row. Those cases, and the correct code for each of the 16 positions, are shown only by the bench scenarios. In those scenarios a behavioural model predicts the rows and pulses cycle by cycle.

// File: rtl/kps_pkg.sv
package kps_pkg;
    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } kps_state_e;
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Stages reset to all ones: idle columns read high.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else begin
                    if (g == 0) begin
                        stage_q[g] <= async_i;
                    end else begin
                        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/kps_colpick.sv
module kps_colpick #(
    parameter int unsigned COLS  = 4,
    localparam int unsigned COL_W = $clog2(COLS)
) (
    input  logic [COLS-1:0]  col_n_i,
    output logic             any_o,
    output logic [COL_W-1:0] idx_o
);
    // Lowest active-low column wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int c = COLS-1; c >= 0; c--) begin
            if (!col_n_i[c]) begin
                any_o = 1'b1;
                idx_o = COL_W'(c);
            end
        end
    end
endmodule

// File: rtl/kps_rowdrv.sv
module kps_rowdrv #(
    parameter int unsigned ROWS  = 4,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0] row_i,
    output logic [ROWS-1:0]  drv_n_o
);
    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            assign drv_n_o[r] = (row_i != ROW_W'(r));
        end
    endgenerate
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner #(
    parameter int unsigned ROWS         = 4,
    parameter int unsigned COLS         = 4,
    parameter int unsigned SETTLE_CYC   = 4,
    parameter int unsigned DEBOUNCE_CYC = 500000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [COLS-1:0]                   col_sense_n,
    output logic [ROWS-1:0]                   row_drv_n,
    output logic [$clog2(ROWS*COLS)-1:0]      key_code,
    output logic                              key_valid
);
    import kps_pkg::*;

    localparam int unsigned ROW_W   = $clog2(ROWS);
    localparam int unsigned COL_W   = $clog2(COLS);
    localparam int unsigned CODE_W  = $clog2(ROWS*COLS);
    localparam int unsigned CNT_MAX = (DEBOUNCE_CYC > SETTLE_CYC) ? DEBOUNCE_CYC : SETTLE_CYC;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        kps_state_e        st;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [CODE_W-1:0] code;
    } kps_regs_t;

    kps_regs_t r_d, r_q;

    logic [COLS-1:0]  col_s;
    logic             col_any;
    logic [COL_W-1:0] col_idx;
    logic [ROW_W-1:0] row_next;
    logic             settle_end;
    logic             deb_end;

    kps_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (col_sense_n),
        .sync_o  (col_s)
    );

    kps_colpick #(.COLS(COLS)) pick_i (
        .col_n_i (col_s),
        .any_o   (col_any),
        .idx_o   (col_idx)
    );

    kps_rowdrv #(.ROWS(ROWS)) drv_i (
        .row_i   (r_q.row),
        .drv_n_o (row_drv_n)
    );

    assign row_next   = (r_q.row == ROW_W'(ROWS-1)) ? '0 : r_q.row + 1'b1;
    assign settle_end = (r_q.cnt == CNT_W'(SETTLE_CYC-1));
    assign deb_end    = (r_q.cnt == CNT_W'(DEBOUNCE_CYC-1));

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.st)
            ST_SCAN: begin
                if (settle_end) begin
                    r_d.cnt = '0;
                    if (col_any) begin
                        r_d.col = col_idx;
                        r_d.st  = ST_WAIT;
                    end else begin
                        r_d.row = row_next;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (deb_end) begin
                    r_d.cnt = '0;
                    if (!col_s[r_q.col]) begin
                        r_d.valid = 1'b1;
                        r_d.code  = CODE_W'(32'(r_q.row) * COLS + 32'(r_q.col));
                        r_d.st    = ST_HOLD;
                    end else begin
                        r_d.row = row_next;
                        r_d.st  = ST_SCAN;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (&col_s) begin
                    r_d.row = row_next;
                    r_d.cnt = '0;
                    r_d.st  = ST_SCAN;
                end
            end
            default: begin
                r_d = '{st: ST_SCAN, row: '0, col: '0, cnt: '0, valid: 1'b0, code: '0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_SCAN, row: '0, col: '0, cnt: '0, valid: 1'b0, code: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign key_code  = r_q.code;
    assign key_valid = r_q.valid;
endmodule

// File: rtl/kps_scanner_chk.sv
module kps_scanner_chk #(
    parameter int unsigned ROWS   = 4,
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROWS-1:0]   row_drv_n,
    input logic [CODE_W-1:0] key_code,
    input logic              key_valid
);
    // R2
    one_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_drv_n) == 1);

    // R3
    row_step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_drv_n != $past(row_drv_n)) |->
        (row_drv_n == {$past(row_drv_n[ROWS-2:0]), $past(row_drv_n[ROWS-1])}));

    // R5
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R6
    code_moves_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_code != $past(key_code)) |-> key_valid);
endmodule

bind kps_scanner kps_scanner_chk #(.ROWS(ROWS), .CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_drv_n (row_drv_n),
    .key_code  (key_code),
    .key_valid (key_valid)
);

// File: tb/kps_scanner_tb_top.sv
module kps_scanner_tb_top;
    localparam int SETTLE = 4;
    localparam int DEB    = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_n;
    logic [3:0] row_n;
    logic [3:0] code;
    logic       valid;
    logic [15:0] pressed = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] got[$];

    always #5 clk = ~clk;

    kps_scanner #(.SETTLE_CYC(SETTLE), .DEBOUNCE_CYC(DEB)) dut_i (
        .clk (clk), .rst_n (rst_n), .col_sense_n (col_n),
        .row_drv_n (row_n), .key_code (code), .key_valid (valid)
    );

    // Switch matrix: a column is pulled low by any closed key in a driven row.
    always_comb begin
        col_n = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c] && !row_n[r]) col_n[c] = 1'b0;
    end

    // Behavioural reference model.
    int m_st, m_row, m_cnt, m_col;
    logic [3:0] m_s1, m_s2, m_seen;
    logic m_valid;
    logic [3:0] m_code;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_row = 0; m_cnt = 0; m_col = 0;
            m_s1 = 4'hF; m_s2 = 4'hF; m_valid = 0; m_code = 0;
        end else begin
            m_seen = m_s2; m_s2 = m_s1; m_s1 = col_n;
            m_valid = 0;
            if (m_st == 0) begin
                if (m_cnt == SETTLE-1) begin
                    m_cnt = 0;
                    if (m_seen != 4'hF) begin
                        for (int c = 3; c >= 0; c--) if (!m_seen[c]) m_col = c;
                        m_st = 1;
                    end else m_row = (m_row + 1) % 4;
                end else m_cnt++;
            end else if (m_st == 1) begin
                if (m_cnt == DEB-1) begin
                    m_cnt = 0;
                    if (!m_seen[m_col]) begin
                        m_valid = 1; m_code = 4'(m_row*4 + m_col); m_st = 2;
                    end else begin
                        m_row = (m_row + 1) % 4; m_st = 0;
                    end
                end else m_cnt++;
            end else begin
                if (m_seen == 4'hF) begin
                    m_row = (m_row + 1) % 4; m_cnt = 0; m_st = 0;
                end
            end
        end
    end

    // Per-cycle comparison and capture, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (row_n != ~(4'b0001 << m_row)) begin
                errors++;
                $display("FAIL R3 row_drv_n got %b exp %b", row_n, ~(4'b0001 << m_row));
            end
            checks++;
            if (valid != m_valid || (valid && code != m_code)) begin
                errors++;
                $display("FAIL R5 valid/code got %b/%h exp %b/%h", valid, code, m_valid, m_code);
            end
            if (valid) got.push_back(code);
        end
    end

    task automatic press(input logic [15:0] keys, input int hold, input int idle);
        @(negedge clk); pressed = keys;
        repeat (hold) @(negedge clk);
        pressed = '0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic expect_codes(input string req, input int n, input logic [3:0] first);
        checks++;
        if (got.size() != n || (n > 0 && got[0] != first)) begin
            errors++;
            $display("FAIL %s count/code got %0d/%h exp %0d/%h", req, got.size(),
                     (got.size() > 0) ? got[0] : 4'h0, n, first);
        end
        got.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (row_n != 4'b1110 || valid !== 1'b0 || code !== 4'h0) begin
            errors++;
            $display("FAIL R1 reset got %b/%b/%h exp 1110/0/0", row_n, valid, code);
        end
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        expect_codes("R3", 0, 4'h0);               // idle: no codes

        press(16'h0080, 200, 60);                  // key 7
        expect_codes("R6", 1, 4'h7);

        press(16'h0004, 20, 120);                  // R7 glitch shorter than debounce
        expect_codes("R7", 0, 4'h0);

        // R7 bounce at press, then steady
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            pressed = (i % 2 == 0) ? 16'h0800 : 16'h0000;
            repeat (3) @(negedge clk);
        end
        press(16'h0800, 200, 60);
        expect_codes("R7", 1, 4'hB);

        press(16'h2000, 700, 60);                  // R8 long hold, key D
        expect_codes("R8", 1, 4'hD);

        press(16'h0E00, 200, 60);                  // R9 keys 9,A,B in row 2
        expect_codes("R9", 1, 4'h9);

        for (int k = 0; k < 16; k++) begin         // R4 / R6 every position
            press(16'(1 << k), 150, 60);
            expect_codes("R4", 1, 4'(k));
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule